// File: doc/BRIEF.md
# Planar Graphics Pixel Serializer

This block turns video refresh data into a stream of pixel colour indices for graphics display modes. Once per character period it accepts a 32-bit refresh word, treated as four 8-bit planes (plane p occupies bits [8p+7:8p]). It then emits one 8-bit colour index per dot clock. Three planar packings are supported: a two-plane-pair 4 bpp layout, a bit-sliced four-plane 4 bpp layout, and a byte-per-pixel 8 bpp layout. In the 8 bpp layout each pixel is shown twice, so every word still spans eight dot clocks.

In the 4 bpp layouts the 4-bit pixel is first ANDed with a plane-enable mask. It then indexes a 16-entry table of 6-bit colours. The table result becomes the low six bits of the output index, and a 2-bit programmable field supplies the top two bits. The 8 bpp layout skips both the mask and the table and drives the pixel byte straight to the output. The table is written through a simple address/data port.

Top module: `pix_serializer`

## Requirements
- R1: After the synchronous reset, `pix_idx` is 0 and every colour table entry i holds the value i.
- R2: On a clock with `dot_en` and `char_stb` both high, `word_in` and `mode_sel` are captured. Slot 0 of that word appears on `pix_idx` after the second following `dot_en` clock, and one further slot appears per `dot_en` clock after that.
- R3: With `mode_sel` = 0 (odd/even), slot k<4 gives the nibble {plane2[7-2k], plane2[6-2k], plane0[7-2k], plane0[6-2k]}. Slot k>=4 builds its nibble the same way from plane 3 (upper bits) and plane 1 (lower bits), using j=k-4.
- R4: With `mode_sel` = 1 (planar), bit b of the slot-k nibble is bit 7-k of plane b, for b in 0..3.
- R5: With `mode_sel[1]` = 1 (byte mode, values 2 and 3), the pixels of a word are plane 0, plane 1, plane 2 and plane 3, in that order.
- R6: In byte mode each pixel byte is output for two consecutive dot clocks, so slots 2i and 2i+1 both carry plane i.
- R7: In the 4 bpp modes the nibble is ANDed with `plane_mask` before the table lookup.
- R8: In byte mode the output equals the plane byte exactly, whatever `plane_mask`, `idx_hi` and the table contents are.
- R9: In the 4 bpp modes `pix_idx` = {`idx_hi`, table[nibble & `plane_mask`]}.
- R10: A clock with `pal_we` high writes `pal_wdata` into table entry `pal_waddr`. The new value is used by later lookups.
- R11: On a clock with `dot_en` low, nothing advances, and `pix_idx` keeps its value.
- R12: The packing is fixed when a word is loaded. A change of `mode_sel` while a word is being shown does not affect that word.
- R13: If no new word is loaded after slot 7, the slot counter wraps and the same word is shown again from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable; one pixel per high cycle |
| char_stb | input | 1 | Load strobe for a new refresh word (acts only with dot_en) |
| mode_sel | input | 2 | Packing: 0 odd/even, 1 planar, 2 or 3 byte |
| word_in | input | 32 | Refresh word, plane p at bits [8p+7:8p] |
| pal_we | input | 1 | Colour table write enable |
| pal_waddr | input | 4 | Colour table write address |
| pal_wdata | input | 6 | Colour table write data |
| plane_mask | input | 4 | Plane-enable mask for 4 bpp pixels |
| idx_hi | input | 2 | Upper two bits of the output index in 4 bpp modes |
| pix_idx | output | 8 | Registered colour index |

## Verification
The bench aims at the bit orderings most likely to be wrong. If the plane pairs in the odd/even second half are swapped, or the bits are taken LSB-first, the nibble sequence comes out scrambled. If byte mode advances the plane every dot clock, it shows four distinct bytes followed by a repeat instead of four doubled pairs. If the mask or the table leaks into byte mode, the 8 bpp values are corrupted. The bench also changes the mode and stalls `dot_en` in the middle of a word. A design that reads the mode live, or lets the pipeline run during a stall, would then output wrong or skipped pixels. Finally, the bench lets the slot counter wrap without a new load, which catches a counter that stops or runs into stale data.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

  typedef enum logic [1:0] {
    PK_ODDEVEN = 2'd0,
    PK_PLANAR  = 2'd1,
    PK_BYTE    = 2'd2
  } pack_e;

  function automatic pack_e decode_pack(input logic [1:0] sel);
    if (sel[1])      return PK_BYTE;
    else if (sel[0]) return PK_PLANAR;
    else             return PK_ODDEVEN;
  endfunction

endpackage

// File: rtl/ppu_unpack.sv
module ppu_unpack
  import ppu_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dot_en,
  input  logic                      char_stb,
  input  logic [1:0]                mode_sel,
  input  logic [PLANES*PLANE_W-1:0] word_in,
  output logic [PLANE_W-1:0]        raw_q,
  output logic                      byte_q
);
  localparam int WORD_W = PLANES * PLANE_W;
  localparam int SLOT_W = $clog2(PLANE_W);

  logic [WORD_W-1:0]  hold;
  logic [SLOT_W-1:0]  slot;
  pack_e              pack_q;
  logic [PLANE_W-1:0] plane [PLANES];
  logic [PLANE_W-1:0] raw;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign plane[p] = hold[p*PLANE_W +: PLANE_W];
  end

  // slot select: MSB of each plane byte is leftmost
  always_comb begin
    logic [SLOT_W-1:0] col;
    logic [SLOT_W-2:0] pair_n;
    logic [PLANE_W-1:0] hp, lp;
    col    = ~slot;
    pair_n = ~slot[SLOT_W-2:0];
    hp     = slot[SLOT_W-1] ? plane[3] : plane[2];
    lp     = slot[SLOT_W-1] ? plane[1] : plane[0];
    raw    = '0;
    unique case (pack_q)
      PK_BYTE:   raw = plane[slot[SLOT_W-1:1]];
      PK_PLANAR: for (int b = 0; b < PLANES; b++) raw[b] = plane[b][col];
      PK_ODDEVEN: raw[3:0] = {hp[{pair_n, 1'b1}], hp[{pair_n, 1'b0}],
                              lp[{pair_n, 1'b1}], lp[{pair_n, 1'b0}]};
      default:   raw = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      slot   <= '0;
      pack_q <= PK_ODDEVEN;
      raw_q  <= '0;
      byte_q <= 1'b0;
    end else if (dot_en) begin
      raw_q  <= raw;
      byte_q <= (pack_q == PK_BYTE);
      if (char_stb) begin
        hold   <= word_in;
        slot   <= '0;
        pack_q <= decode_pack(mode_sel);
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (dot_en && char_stb) |=> (slot == '0 && hold == $past(word_in))); // R2

  AST_BYTE_DOUBLE: assert property (@(posedge clk) disable iff (rst)
    (dot_en && $past(dot_en) && pack_q == PK_BYTE && slot[0])
      |=> raw_q == $past(raw_q)); // R6

endmodule

// File: rtl/ppu_palette.sv
module ppu_palette #(
  parameter int DEPTH = 16,
  parameter int W     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  // distributed storage: synchronous write, asynchronous read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata)); // R10

endmodule

// File: rtl/ppu_colour.sv
module ppu_colour #(
  parameter int PIX_W = 8,
  parameter int NIB_W = 4,
  parameter int PAL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dot_en,
  input  logic [PIX_W-1:0] raw,
  input  logic             is_byte,
  input  logic [NIB_W-1:0] mask,
  input  logic [PIX_W-PAL_W-1:0] hi,
  input  logic [PAL_W-1:0] pal_data,
  output logic [NIB_W-1:0] pal_addr,
  output logic [PIX_W-1:0] pix_idx
);
  localparam int HI_W = PIX_W - PAL_W;

  assign pal_addr = raw[NIB_W-1:0] & mask;

  always_ff @(posedge clk) begin
    if (rst)         pix_idx <= '0;
    else if (dot_en) pix_idx <= is_byte ? raw : {hi, pal_data};
  end

  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (dot_en && is_byte) |=> pix_idx == $past(raw)); // R8

  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
    (dot_en && !is_byte) |=> pix_idx[PIX_W-1 -: HI_W] == $past(hi)); // R9

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int PLANES    = 4,
  parameter int PLANE_W   = 8,
  parameter int PAL_DEPTH = 16,
  parameter int PAL_W     = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dot_en,
  input  logic                         char_stb,
  input  logic [1:0]                   mode_sel,
  input  logic [PLANES*PLANE_W-1:0]    word_in,
  input  logic                         pal_we,
  input  logic [$clog2(PAL_DEPTH)-1:0] pal_waddr,
  input  logic [PAL_W-1:0]             pal_wdata,
  input  logic [PLANES-1:0]            plane_mask,
  input  logic [PLANE_W-PAL_W-1:0]     idx_hi,
  output logic [PLANE_W-1:0]           pix_idx
);
  localparam int PAL_AW = $clog2(PAL_DEPTH);

  logic [PLANE_W-1:0] raw_q;
  logic               byte_q;
  logic [PAL_AW-1:0]  pal_raddr;
  logic [PAL_W-1:0]   pal_rdata;

  ppu_unpack #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_unpack (
    .clk(clk), .rst(rst), .dot_en(dot_en), .char_stb(char_stb),
    .mode_sel(mode_sel), .word_in(word_in), .raw_q(raw_q), .byte_q(byte_q)
  );

  ppu_palette #(.DEPTH(PAL_DEPTH), .W(PAL_W)) u_palette (
    .clk(clk), .rst(rst), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .raddr(pal_raddr), .rdata(pal_rdata)
  );

  ppu_colour #(.PIX_W(PLANE_W), .NIB_W(PLANES), .PAL_W(PAL_W)) u_colour (
    .clk(clk), .rst(rst), .dot_en(dot_en), .raw(raw_q), .is_byte(byte_q),
    .mask(plane_mask), .hi(idx_hi), .pal_data(pal_rdata),
    .pal_addr(pal_raddr), .pix_idx(pix_idx)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dot_en |=> $stable(pix_idx)); // R11

endmodule

// File: tb/sim_pix_serializer.sv
module sim_pix_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dot_en = 1'b1;
  logic        char_stb = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [31:0] word_in = '0;
  logic        pal_we = 1'b0;
  logic [3:0]  pal_waddr = '0;
  logic [5:0]  pal_wdata = '0;
  logic [3:0]  plane_mask = 4'hF;
  logic [1:0]  idx_hi = 2'd0;
  logic [7:0]  pix_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [5:0] pal_m [16];

  always #10 clk = ~clk;

  pix_serializer u0 (
    .clk(clk), .rst(rst), .dot_en(dot_en), .char_stb(char_stb),
    .mode_sel(mode_sel), .word_in(word_in), .pal_we(pal_we),
    .pal_waddr(pal_waddr), .pal_wdata(pal_wdata), .plane_mask(plane_mask),
    .idx_hi(idx_hi), .pix_idx(pix_idx)
  );

  function automatic logic [7:0] exp_pix(input logic [31:0] w, input logic [1:0] m,
                                         input int k);
    logic [7:0] p [4];
    logic [3:0] nib;
    int j;
    for (int i = 0; i < 4; i++) p[i] = w[8*i +: 8];
    if (m[1]) return p[k/2];
    if (m[0]) begin
      for (int b = 0; b < 4; b++) nib[b] = p[b][7-k];
    end else if (k < 4) begin
      j = k;
      nib = {p[2][7-2*j], p[2][6-2*j], p[0][7-2*j], p[0][6-2*j]};
    end else begin
      j = k - 4;
      nib = {p[3][7-2*j], p[3][6-2*j], p[1][7-2*j], p[1][6-2*j]};
    end
    return {idx_hi, pal_m[nib & plane_mask]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic [31:0] w, input logic [1:0] m);
    @(negedge clk); char_stb = 1'b1; word_in = w; mode_sel = m;
    @(negedge clk); char_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_word(input string tag, input logic [31:0] w,
                          input logic [1:0] m, input int npix);
    load_word(w, m);
    for (int k = 0; k < npix; k++) begin
      @(negedge clk);
      chk(tag, pix_idx, exp_pix(w, m, k % 8));
    end
  endtask

  task automatic pal_write(input logic [3:0] a, input logic [5:0] d);
    @(negedge clk); pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
    @(negedge clk); pal_we = 1'b0;
    pal_m[a] = d;
  endtask

  task automatic t_reset();
    chk("R1 reset index", pix_idx, 8'h00);
    // identity table after reset: planar output equals the nibble
    run_word("R1 R4 planar identity table", 32'hF0CC_AA55, 2'd1, 8);
  endtask

  task automatic t_oddeven();
    run_word("R3 odd/even", 32'h1B2D_E487, 2'd0, 8);
    run_word("R3 odd/even b", 32'hC3A5_5A3C, 2'd0, 8);
  endtask

  task automatic t_byte();
    idx_hi = 2'd3; plane_mask = 4'h0;
    run_word("R5 R6 R8 byte order/double/bypass", 32'h8811_C37E, 2'd2, 8);
    run_word("R5 R8 byte mode 3", 32'h0F5A_A5F0, 2'd3, 8);
    idx_hi = 2'd0; plane_mask = 4'hF;
  endtask

  task automatic t_palette();
    for (int i = 0; i < 16; i++) pal_write(4'(i), 6'((i * 5 + 3) & 63));
    idx_hi = 2'd2;
    run_word("R10 R9 planar table", 32'h3C69_96C3, 2'd1, 8);
    run_word("R10 R9 odd/even table", 32'h71E2_9B4D, 2'd0, 8);
  endtask

  task automatic t_mask();
    plane_mask = 4'b0011;
    run_word("R7 mask 0011", 32'hFF0F_F0AA, 2'd1, 8);
    plane_mask = 4'b1010;
    run_word("R7 mask 1010", 32'h5AC3_3CA5, 2'd0, 8);
    plane_mask = 4'hF;
  endtask

  task automatic t_hold();
    logic [31:0] w = 32'h9D2C_4BE6;
    load_word(w, 2'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R2 R11 pre-stall", pix_idx, exp_pix(w, 2'd1, k));
    end
    dot_en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); chk("R11 stall holds", pix_idx, exp_pix(w, 2'd1, 2));
    end
    dot_en = 1'b1;
    for (int k = 3; k < 8; k++) begin
      @(negedge clk); chk("R11 resume", pix_idx, exp_pix(w, 2'd1, k));
    end
  endtask

  task automatic t_mode_latch();
    logic [31:0] w = 32'hA1B2_C3D4;
    load_word(w, 2'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chk("R12 mode latched", pix_idx, exp_pix(w, 2'd1, k));
      mode_sel = 2'd2;
    end
  endtask

  task automatic t_repeat();
    run_word("R13 wrap repeat", 32'h6E17_D8B3, 2'd0, 16);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = 6'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oddeven();
    t_byte();
    t_palette();
    t_mask();
    t_hold();
    t_mode_latch();
    t_repeat();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule